// File: doc/BRIEF.md
# Elastic Store with Count-Eight Phase Comparator

This block is a small circular data buffer that sits between a producer and a consumer that should run at the same average rate. The producer presents a data element with a write enable. The consumer side reads on a read strobe that the block makes itself, by dividing an oscillator tick input by 2N. Each read places the element at the read pointer on a registered output that feeds the next decoding stage. Both pointers are 4 bits wide by default, so the store holds 16 elements. After reset the pointers sit half the store apart.

The block also watches the most significant bit of each pointer, the one that switches every eight accesses. When the write pointer's top bit falls before the read pointer's top bit, the block raises an advance request. That request asks an external loop filter and oscillator to speed up the tick. When the read side falls first, the block raises a retard request instead. Each request lasts from the first falling edge to the matching edge on the other pointer. A slip flag pulses whenever an access takes place while the two pointers are equal. The whole block runs on one system clock.

Top module: `elastic_store_pc`

## Requirements
- R1: During and after reset, and before any access: rd_data_o, rd_valid_o, advance_o, retard_o and slip_o are 0. The write pointer is 0, the read pointer is 8, and every store entry holds 0, so the first eight reads return 0.
- R2: Each cycle with wr_en_i high writes wr_data_i at the write pointer and advances that pointer. Without a slip, reads return the written elements in write order, following the eight reset entries.
- R3: A read happens on every 2·DIV_N-th cycle that has osc_tick_i high. On the clock edge of that read, rd_data_o loads the element and rd_valid_o goes high for one cycle. With DIV_N=8, a steady tick gives one read every 16 cycles, and a tick on alternate cycles gives one read every 32 cycles.
- R4: When the read pointer's bit 3 falls while no request is active and the write bit 3 does not fall in that cycle, retard_o rises one cycle after the pointer change. It stays high until the write pointer's bit 3 falls, and it drops one cycle after that change, which is two cycles after the wrapping write's edge.
- R5: When the write pointer's bit 3 falls while no request is active and the read bit 3 does not fall in that cycle, advance_o rises two cycles after the wrapping write's edge. It stays high until the read pointer's bit 3 falls, and it drops one cycle after rd_valid_o shows that read.
- R6: advance_o and retard_o are never high together.
- R7: slip_o pulses for one cycle after any read or write edge at which the write pointer equals the read pointer.
- R8: When writes and reads run at the same rate from reset, slip_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one element per high cycle |
| wr_data_i | input | DW | Element to store |
| osc_tick_i | input | 1 | Oscillator tick feeding the read divider |
| rd_data_o | output | DW | Element from the latest read |
| rd_valid_o | output | 1 | High for one cycle after each read |
| advance_o | output | 1 | Request to speed up the read rate |
| retard_o | output | 1 | Request to slow down the read rate |
| slip_o | output | 1 | Pointer collision on an access |

## Verification
The bench runs a balanced stream in which each write is matched by a read. A scoreboard checks the read data, the read period and the absence of slips. A design with the wrong reset offset or the wrong read address would return data out of order or flag slips here. Two directed runs starve one side on purpose so that a single pointer wraps first. They then time the rise, the hold and the exact fall cycle of the matching request. A comparator that swapped the two outputs, reacted to rising edges, or cleared a cycle early or late would fail these timing checks. A tick on alternate cycles checks that the divider counts ticks rather than clocks. The starved runs also drive the pointers into collision, to confirm that the slip pulse appears.

// File: rtl/es_pkg.sv
package es_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_WR_LEAD = 2'd1,
    PH_RD_LEAD = 2'd2
  } ph_state_e;
endpackage

// File: rtl/es_rclk_div.sv
module es_rclk_div #(
  parameter int DIV_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic rd_en_o
);
  localparam int TERM = 2 * DIV_N;
  localparam int CW   = (TERM > 2) ? $clog2(TERM) : 1;

  logic [CW-1:0] cnt_q;
  logic          last_tick;

  assign last_tick = (cnt_q == CW'(TERM - 1));
  assign rd_en_o   = tick_i && last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= last_tick ? '0 : cnt_q + 1'b1;
  end

  // two reads need at least two ticks
  assert_rd_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);
  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(TERM - 1));
endmodule

// File: rtl/es_ptr_ctr.sv
module es_ptr_ctr #(
  parameter int          AW      = 4,
  parameter logic [AW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= RST_VAL;
    else if (en_i) ptr_o <= ptr_o + 1'b1;
  end

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ptr_o == AW'($past(ptr_o) + 1'b1));
  assert_ptr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_o));
endmodule

// File: rtl/es_store.sv
module es_store #(
  parameter int AW = 4,
  parameter int DW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem_q[rd_addr_i];
    end
  end

  assert_wr_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/es_phase_cmp.sv
module es_phase_cmp
  import es_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_msb_i,
  input  logic rd_msb_i,
  output logic advance_o,
  output logic retard_o
);
  logic      wr_msb_q, rd_msb_q;
  logic      wr_fall, rd_fall;
  ph_state_e state_q, state_d;

  assign wr_fall = wr_msb_q && !wr_msb_i;
  assign rd_fall = rd_msb_q && !rd_msb_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: begin
        if (wr_fall && !rd_fall)      state_d = PH_WR_LEAD;
        else if (rd_fall && !wr_fall) state_d = PH_RD_LEAD;
      end
      PH_WR_LEAD: if (rd_fall) state_d = PH_IDLE;
      PH_RD_LEAD: if (wr_fall) state_d = PH_IDLE;
      default:    state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_msb_q <= 1'b0;
      rd_msb_q <= 1'b0;
      state_q  <= PH_IDLE;
    end else begin
      wr_msb_q <= wr_msb_i;
      rd_msb_q <= rd_msb_i;
      state_q  <= state_d;
    end
  end

  assign advance_o = (state_q == PH_WR_LEAD);
  assign retard_o  = (state_q == PH_RD_LEAD);

  assert_req_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(advance_o && retard_o));
  assert_adv_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(advance_o) |-> $past(wr_msb_i, 2) && !$past(wr_msb_i));
  assert_adv_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(advance_o) |-> $past(rd_msb_i, 2) && !$past(rd_msb_i));
  assert_ret_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retard_o) |-> $past(rd_msb_i, 2) && !$past(rd_msb_i));
  assert_ret_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(retard_o) |-> $past(wr_msb_i, 2) && !$past(wr_msb_i));
endmodule

// File: rtl/elastic_store_pc.sv
module elastic_store_pc #(
  parameter int AW    = 4,
  parameter int DW    = 3,
  parameter int DIV_N = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          osc_tick_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          advance_o,
  output logic          retard_o,
  output logic          slip_o
);
  localparam logic [AW-1:0] RD_START = AW'(1 << (AW - 1));

  logic          rd_en;
  logic [AW-1:0] wr_ptr, rd_ptr;

  es_rclk_div #(.DIV_N(DIV_N)) u_div (
    .clk_i, .rst_ni, .tick_i(osc_tick_i), .rd_en_o(rd_en)
  );

  es_ptr_ctr #(.AW(AW), .RST_VAL('0)) u_wr_ptr (
    .clk_i, .rst_ni, .en_i(wr_en_i), .ptr_o(wr_ptr)
  );

  es_ptr_ctr #(.AW(AW), .RST_VAL(RD_START)) u_rd_ptr (
    .clk_i, .rst_ni, .en_i(rd_en), .ptr_o(rd_ptr)
  );

  es_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_addr_i(wr_ptr), .wr_data_i,
    .rd_en_i(rd_en), .rd_addr_i(rd_ptr),
    .rd_data_o, .rd_valid_o
  );

  es_phase_cmp u_cmp (
    .clk_i, .rst_ni,
    .wr_msb_i(wr_ptr[AW-1]), .rd_msb_i(rd_ptr[AW-1]),
    .advance_o, .retard_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slip_o <= 1'b0;
    else         slip_o <= (wr_en_i || rd_en) && (wr_ptr == rd_ptr);
  end

  assert_slip_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> $past(wr_en_i) || $past(osc_tick_i));
  assert_rd_valid_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(osc_tick_i));
endmodule

// File: tb/elastic_store_pc_tb_top.sv
`timescale 1ns/1ps
module elastic_store_pc_tb_top;
  localparam int DW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          osc_tick_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o, advance_o, retard_o, slip_o;

  elastic_store_pc #(.AW(4), .DW(DW), .DIV_N(8)) dut_i (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int cyc = 0;
  int tick_mode = 0;
  int slip_cnt = 0, excl_err = 0, per_err = 0, rd_cnt = 0;
  int last_rd = -1, exp_per = 16;
  bit sb_on = 0, per_chk = 0;
  logic [DW-1:0] exp_q [$];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // tick driver
  initial forever begin
    @(negedge clk_i);
    case (tick_mode)
      1:       osc_tick_i = 1'b1;
      2:       osc_tick_i = ~osc_tick_i;
      default: osc_tick_i = 1'b0;
    endcase
  end

  // monitor / scoreboard
  initial forever begin
    @(negedge clk_i);
    if (rst_ni) begin
      if (advance_o && retard_o) excl_err++;
      if (slip_o) slip_cnt++;
      if (rd_valid_o) begin
        rd_cnt++;
        if (per_chk && last_rd >= 0 && (cyc - last_rd) != exp_per) per_err++;
        last_rd = cyc;
        if (sb_on) begin
          if (exp_q.size() == 0) chk(1'b0, "R2 read with empty scoreboard", int'(rd_data_o), -1);
          else begin
            automatic logic [DW-1:0] e = exp_q.pop_front();
            chk(rd_data_o == e, "R2 read data order", int'(rd_data_o), int'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  task automatic do_reset();
    rst_ni = 1'b0; wr_en_i = 1'b0; tick_mode = 0;
    sb_on = 0; per_chk = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    slip_cnt = 0; rd_cnt = 0; last_rd = -1; per_err = 0;
  endtask

  task automatic write_one(input logic [DW-1:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic write_burst16();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = DW'(i);
    end
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  initial begin
    // R1 reset state
    @(negedge clk_i);
    chk(rd_data_o == '0, "R1 rd_data reset", int'(rd_data_o), 0);
    chk(!rd_valid_o, "R1 rd_valid reset", rd_valid_o, 0);
    chk(!advance_o && !retard_o, "R1 requests reset", {advance_o, retard_o}, 0);
    chk(!slip_o, "R1 slip reset", slip_o, 0);
    do_reset();

    // balanced stream: R1 zeros first, R2 order, R3 period, R8 no slip
    for (int i = 0; i < 8; i++) exp_q.push_back('0);
    exp_per = 16; per_chk = 1; sb_on = 1; tick_mode = 1;
    for (int i = 0; i < 40; i++) begin
      automatic logic [DW-1:0] d = DW'(i * 5 + 3);
      exp_q.push_back(d);
      write_one(d);
      repeat (14) @(negedge clk_i);
    end
    while (exp_q.size() != 0) @(negedge clk_i);
    tick_mode = 0; sb_on = 0; per_chk = 0;
    chk(rd_cnt == 48, "R2 read count", rd_cnt, 48);
    chk(per_err == 0, "R3 read period 16", per_err, 0);
    chk(slip_cnt == 0, "R8 no slip when balanced", slip_cnt, 0);

    // read side wraps first: R4 retard, R7 slip
    do_reset();
    tick_mode = 1;
    while (!retard_o) begin
      @(negedge clk_i);
      if (advance_o) break;
    end
    chk(!advance_o, "R4 no advance when read leads", advance_o, 0);
    repeat (20) @(negedge clk_i);
    chk(retard_o, "R4 retard held", retard_o, 1);
    chk(!advance_o, "R6 advance low during retard", advance_o, 0);
    chk(slip_cnt >= 1, "R7 slip on read collision", slip_cnt, 1);
    tick_mode = 0;
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = DW'(i);
    end
    @(negedge clk_i); wr_en_i = 1'b0;
    chk(retard_o, "R4 retard still high one cycle after wrap write", retard_o, 1);
    @(negedge clk_i);
    chk(!retard_o, "R4 retard cleared two cycles after wrap write", retard_o, 0);
    chk(!advance_o, "R4 no advance after clear", advance_o, 0);

    // write side wraps first: R5 advance, R7 slip, R3 half-rate tick
    do_reset();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = DW'(i);
    end
    @(negedge clk_i); wr_en_i = 1'b0;
    chk(!advance_o, "R5 advance not yet one cycle after wrap", advance_o, 0);
    @(negedge clk_i);
    chk(advance_o, "R5 advance two cycles after wrap", advance_o, 1);
    repeat (10) @(negedge clk_i);
    chk(advance_o, "R5 advance held", advance_o, 1);
    chk(!retard_o, "R6 retard low during advance", retard_o, 0);
    chk(slip_cnt >= 1, "R7 slip on write collision", slip_cnt, 1);
    exp_per = 32; last_rd = -1; per_err = 0; per_chk = 1; tick_mode = 2;
    begin
      int seen = 0;
      while (seen < 8) begin
        @(negedge clk_i);
        if (rd_valid_o) seen++;
      end
    end
    chk(advance_o, "R5 advance high at eighth read", advance_o, 1);
    @(negedge clk_i);
    chk(!advance_o, "R5 advance cleared after read wrap", advance_o, 0);
    tick_mode = 0; per_chk = 0;
    chk(per_err == 0, "R3 read period 32 with half-rate tick", per_err, 0);
    chk(excl_err == 0, "R6 requests exclusive", excl_err, 0);

    summary();
  end
endmodule